// File: doc/BRIEF.md
# Phase-Frequency Detector with Pump Test Controls

This block compares two divided clock-like streams, a reference stream and a feedback stream, and drives the up and down requests of a charge pump. Both inputs are asynchronous to the fast system clock. Each input passes through a synchronizer chain of configurable depth, and an extra register then detects its rising transitions. A three-state tracker (idle, pumping up, pumping down) turns the ordering of these edges into pulses. A pulse lasts as many system clocks as the two edges are apart. Because the tracker has three states, it acts as a frequency detector as well as a phase detector, so its average output stays monotonic across a full two-cycle span of phase error.

Three control bits act after the tracker, in plain combinational logic. One bit reverses the sense of the detector, for a loop with a negative-gain oscillator or an inverting filter. The other two bits separately allow or block the up and down requests. When both requests are blocked, a flag reports that the pump output should float. Changing the controls never disturbs the tracked phase state.

Top module: `phase_detector_tc`

## Requirements
- R1: While the synchronous reset `rst` is high, and on the first cycle after it, both pump requests are low and the tracker is idle.
- R2: When a reference rising edge precedes a feedback rising edge by D system clocks, `pump_up` (with `invert_sense`=0) is high for exactly D consecutive cycles. Each output responds SYNC_STAGES+1 clocks after its input edge is driven.
- R3: When a feedback rising edge precedes a reference rising edge by D clocks, `pump_dn` (with `invert_sense`=0) is high for exactly D cycles.
- R4: Rising edges on both inputs that are recognised in the same clock leave the tracker state unchanged, so from idle neither request is raised.
- R5: With `invert_sense`=1, the roles are swapped: a leading reference edge drives `pump_dn`, and a leading feedback edge drives `pump_up`.
- R6: With `up_allow`=0, `pump_up` is always low.
- R7: With `dn_allow`=0, `pump_dn` is always low.
- R8: `pump_float` is 1 exactly when `up_allow` and `dn_allow` are both 0, and the tracker keeps running while it is set.
- R9: A change to the control bits leaves the tracker state unchanged. If a blocked request is re-enabled while its pulse is pending, that request appears on the next cycle.
- R10: `pump_up` and `pump_dn` are never high in the same cycle.
- R11: Further reference edges that arrive while pumping up keep the tracker in the up state. Only a feedback edge returns it to idle (and symmetrically for down).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than either input stream |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Divided reference stream (asynchronous) |
| fb_in | input | 1 | Divided feedback stream (asynchronous) |
| invert_sense | input | 1 | 1 = swap the up and down roles |
| up_allow | input | 1 | 0 = block the up request |
| dn_allow | input | 1 | 0 = block the down request |
| pump_up | output | 1 | Charge-pump up request |
| pump_dn | output | 1 | Charge-pump down request |
| pump_float | output | 1 | Both requests blocked; the pump output floats |

## Verification
The bench builds the block with SYNC_STAGES=3 rather than the default of 2. A behavioural model that is independent of the depth must therefore predict the longer input-to-output latency, which exposes any pulse-width error caused by a mismatch between the synchronizer and the edge register. Each stimulus is a waveform of 40 cycles, which lets the bench place edges with an exact spacing. With it, the bench covers swapped edge orders, coincident edges, repeated reference edges, and a request that is re-enabled in the middle of its pulse. It also covers every combination of polarity and blocking.

// File: rtl/phase_detector_tc.sv
module phase_detector_tc #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  input  logic invert_sense,
  input  logic up_allow,
  input  logic dn_allow,
  output logic pump_up,
  output logic pump_dn,
  output logic pump_float
);
  localparam int SH_W = SYNC_STAGES + 1;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_UP = 2'd1, ST_DN = 2'd2} trk_t;

  logic [SH_W-1:0] ref_sh, fb_sh;
  logic            ref_edge, fb_edge;
  trk_t            state, state_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sh <= '0;
      fb_sh  <= '0;
    end else begin
      ref_sh <= {ref_sh[SH_W-2:0], ref_in};
      fb_sh  <= {fb_sh[SH_W-2:0], fb_in};
    end
  end

  assign ref_edge = ref_sh[SH_W-2] & ~ref_sh[SH_W-1];
  assign fb_edge  = fb_sh[SH_W-2]  & ~fb_sh[SH_W-1];

  always_comb begin
    state_nx = state;
    if (ref_edge && !fb_edge) begin
      case (state)
        ST_IDLE: state_nx = ST_UP;
        ST_DN:   state_nx = ST_IDLE;
        default: state_nx = ST_UP;
      endcase
    end else if (fb_edge && !ref_edge) begin
      case (state)
        ST_IDLE: state_nx = ST_DN;
        ST_UP:   state_nx = ST_IDLE;
        default: state_nx = ST_DN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  logic raw_up, raw_dn;
  assign raw_up = (state == ST_UP);
  assign raw_dn = (state == ST_DN);

  assign pump_up    = (invert_sense ? raw_dn : raw_up) & up_allow;
  assign pump_dn    = (invert_sense ? raw_up : raw_dn) & dn_allow;
  assign pump_float = ~up_allow & ~dn_allow;
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker (
  input logic       clk,
  input logic       rst,
  input logic       ref_edge,
  input logic       fb_edge,
  input logic [1:0] st,
  input logic       invert_sense,
  input logic       up_allow,
  input logic       dn_allow,
  input logic       pump_up,
  input logic       pump_dn,
  input logic       pump_float
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (st == 2'd0 && !pump_up && !pump_dn));

  assert_ref_starts_up_R2: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0 && ref_edge && !fb_edge) |=> (st == 2'd1));

  assert_fb_starts_dn_R3: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd0 && fb_edge && !ref_edge) |=> (st == 2'd2));

  assert_coincident_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (ref_edge && fb_edge) |=> $stable(st));

  assert_float_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    pump_float |-> (!pump_up && !pump_dn));

  assert_ctrl_keeps_state_R9: assert property (@(posedge clk) disable iff (rst)
    (!ref_edge && !fb_edge) |=> $stable(st));

  assert_never_both_R10: assert property (@(posedge clk) disable iff (rst)
    !(pump_up && pump_dn));

  assert_up_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (st == 2'd1 && ref_edge && !fb_edge) |=> (st == 2'd1));
endmodule

bind phase_detector_tc pfd_checker chk_i (
  .clk(clk), .rst(rst), .ref_edge(ref_edge), .fb_edge(fb_edge), .st(state),
  .invert_sense(invert_sense), .up_allow(up_allow), .dn_allow(dn_allow),
  .pump_up(pump_up), .pump_dn(pump_dn), .pump_float(pump_float)
);

// File: tb/phase_detector_tc_tb_top.sv
module phase_detector_tc_tb_top;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic invert_sense = 1'b0, up_allow = 1'b1, dn_allow = 1'b1;
  logic pump_up, pump_dn, pump_float;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  phase_detector_tc #(.SYNC_STAGES(N)) dut_i (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .invert_sense(invert_sense), .up_allow(up_allow), .dn_allow(dn_allow),
    .pump_up(pump_up), .pump_dn(pump_dn), .pump_float(pump_float)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural model: delay queues and a clamped phase score
  logic rq[$];
  logic fq[$];
  int   score = 0;

  always @(posedge clk) begin
    if (rst) begin
      rq = {};
      fq = {};
      for (int i = 0; i < N + 2; i++) begin
        rq.push_back(1'b0);
        fq.push_back(1'b0);
      end
      score = 0;
    end else begin
      bit re, fe;
      rq.push_front(ref_in); void'(rq.pop_back());
      fq.push_front(fb_in);  void'(fq.pop_back());
      re = rq[N] && !rq[N+1];
      fe = fq[N] && !fq[N+1];
      if (re && !fe) score = (score < 1) ? score + 1 : 1;
      if (fe && !re) score = (score > -1) ? score - 1 : -1;
    end
  end

  always @(negedge clk) begin
    if (!rst && rq.size() == N + 2) begin
      int eu, ed;
      eu = invert_sense ? (score == -1) : (score == 1);
      ed = invert_sense ? (score == 1) : (score == -1);
      check("R2 model up", int'(pump_up), eu & int'(up_allow));
      check("R3 model dn", int'(pump_dn), ed & int'(dn_allow));
      check("R8 model float", int'(pump_float), int'(!up_allow && !dn_allow));
      check("R10 exclusive", int'(pump_up && pump_dn), 0);
    end
  end

  task automatic run_wave(input logic [39:0] rw, input logic [39:0] fw,
                          output int nup, output int ndn);
    nup = 0; ndn = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      nup += int'(pump_up);
      ndn += int'(pump_dn);
      #1;
      ref_in = rw[c];
      fb_in  = fw[c];
    end
    @(negedge clk); #1;
    ref_in = 1'b0; fb_in = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  function automatic logic [39:0] step(input int d);
    return ~40'h0 << d;
  endfunction

  initial begin
    int u, d;
    repeat (3) @(negedge clk);
    check("R1 reset up", int'(pump_up), 0);
    check("R1 reset dn", int'(pump_dn), 0);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", int'(pump_up || pump_dn), 0);

    run_wave(step(2), step(7), u, d);
    check("R2 up width", u, 5); check("R2 no dn", d, 0);

    run_wave(step(9), step(6), u, d);
    check("R3 dn width", d, 3); check("R3 no up", u, 0);

    run_wave(step(4), step(4), u, d);
    check("R4 coincident", u + d, 0);

    invert_sense = 1'b1;
    run_wave(step(1), step(5), u, d);
    check("R5 inverted dn", d, 4); check("R5 inverted up", u, 0);
    run_wave(step(8), step(10), u, d);
    check("R5 inverted fb-lead... up", u, 0);
    check("R5 inverted dn again", d, 2);
    run_wave(step(10), step(3), u, d);
    check("R5 inverted fb lead up", u, 7);
    invert_sense = 1'b0;

    up_allow = 1'b0;
    run_wave(step(2), step(8), u, d);
    check("R6 up blocked", u, 0);
    up_allow = 1'b1;

    dn_allow = 1'b0;
    run_wave(step(9), step(2), u, d);
    check("R7 dn blocked", d, 0);

    up_allow = 1'b0;
    @(negedge clk);
    check("R8 float set", int'(pump_float), 1);
    run_wave(step(3), step(9), u, d);
    check("R8 float quiet", u + d, 0);
    up_allow = 1'b1; dn_allow = 1'b1;
    @(negedge clk);
    check("R8 float clear", int'(pump_float), 0);

    // R9: block up, start a pulse, re-enable mid-pulse
    up_allow = 1'b0;
    @(negedge clk); #1 ref_in = 1'b1;
    repeat (N + 4) @(negedge clk);
    check("R9 held blocked", int'(pump_up), 0);
    #1 up_allow = 1'b1;
    @(negedge clk);
    check("R9 resumes", int'(pump_up), 1);
    #1 fb_in = 1'b1;
    repeat (N + 3) @(negedge clk);
    check("R9 ends", int'(pump_up), 0);
    #1 ref_in = 1'b0; fb_in = 1'b0;
    repeat (8) @(negedge clk);

    run_wave(~40'h0 & ~40'hC, step(10), u, d);
    check("R11 up held", u, 10); check("R11 no dn", d, 0);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule